// File: doc/BRIEF.md
# Windowed SRAM Access Bridge

This block lets a host that owns only a small 32-bit register space read and write a much larger on-card SRAM. The host first loads a window base register. Every word access that then lands in a fixed 2 KB aperture of the register space goes to the SRAM. The upper bits of the base select which 2 KB window is reached, and the aperture offset selects the word inside that window. A separate single-word data register reaches the SRAM word at the full base address, with no aperture offset added.

Each register access is one cycle on a simple strobe port. A read returns its data, with a valid flag, on the following cycle. The SRAM side is a synchronous single-port memory that returns read data one cycle after its enable. The implemented SRAM is a number of equal banks. Any access whose address falls beyond the last bank never reaches the memory.

Top module: `wbr_window_bridge`

## Requirements
- R1: The window base register (register offset 0x68) resets to zero and reads back exactly the 32 bits last written to it.
- R2: A word access at register offset 0x800+o, with o in 0..0x7FC, addresses the SRAM byte {base[31:11], o[10:0]}. It drives the SRAM word address of that byte, with the write data on a write.
- R3: Bits [10:0] of the window base have no effect on aperture accesses.
- R4: The window data register (offset 0x6C) reads and writes the SRAM word that holds byte address base. Base bits [1:0] are ignored, and so are register address bits [1:0] on every access.
- R5: Each read strobe that is not paired with a write strobe produces exactly one read-valid pulse, on the next cycle, and no valid appears otherwise. Reads on consecutive cycles return their data in issue order.
- R6: An aperture or data-register access whose byte address is at or above NUM_BANKS × 2^BANK_BYTE_AW starts no SRAM operation and reads as zero. This includes addresses whose upper base bits are set.
- R7: Register offsets other than the base register, the data register and the aperture read as zero, and writes to them change nothing.
- R8: An aperture offset never carries into the base. Reaching the next 2 KB window needs a new base value, and a write at the top of one window leaves the following window untouched.
- R9: Accesses to the base register never start an SRAM operation, and the SRAM write enable is only ever high together with the SRAM enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | REG_AW | Host register byte address |
| reg_wdata | input | 32 | Host write data |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_rdata | output | 32 | Host read data, meaningful while reg_rvalid is high |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | SRAM_WAW | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, one cycle after a read enable |

## Verification
The bench builds the bridge with 4 KB banks and three of them, so the limit is 12 KB. That limit is not a power of two, and it falls inside the word address the SRAM port can express. An access just past the limit therefore shows whether the range check compares against the true size or only trims address width. With 12 KB, six aperture windows are in range and the seventh is out of range. This puts the last in-range word, the first dropped word, and an aliasing high-base address within a few register writes of each other.

// File: rtl/wbr_pkg.sv
// Package: shared types for the windowed SRAM bridge.
// Assumes: 32-bit host data and 32-bit window base.
package wbr_pkg;

    localparam int DATA_W = 32;

    // Which register target a host access decodes to
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_BASE = 2'd1,
        TGT_DATA = 2'd2,
        TGT_APER = 2'd3
    } wbr_tgt_e;

    // Where the read-return stage takes its data from
    typedef enum logic [1:0] {
        RSRC_ZERO = 2'd0,
        RSRC_BASE = 2'd1,
        RSRC_SRAM = 2'd2
    } wbr_rsrc_e;

endpackage

// File: rtl/wbr_decode.sv
// Module: wbr_decode
// Maps a host register byte address onto one of the bridge targets.
// Assumes: offsets are word aligned; APER_OFS is aligned to the aperture
// size; address bits [1:0] are not decoded.
module wbr_decode
    import wbr_pkg::*;
#(
    parameter int REG_AW   = 12,
    parameter int WIN_AW   = 11,
    parameter int APER_OFS = 'h800,
    parameter int BASE_OFS = 'h68,
    parameter int DATA_OFS = 'h6C
) (
    input  logic [REG_AW-1:0] addr,
    output wbr_tgt_e          tgt
);

    localparam int WORD_AW = REG_AW - 2;
    localparam logic [WORD_AW-1:0] BASE_W = WORD_AW'(BASE_OFS >> 2);
    localparam logic [WORD_AW-1:0] DATA_W_OFS = WORD_AW'(DATA_OFS >> 2);
    localparam int TAG_W = REG_AW - WIN_AW;
    localparam logic [TAG_W-1:0] APER_TAG = TAG_W'(APER_OFS >> WIN_AW);

    logic [WORD_AW-1:0] word;
    assign word = addr[REG_AW-1:2];

    // Target selection: aperture first, then the two single registers
    always_comb begin
        if (addr[REG_AW-1:WIN_AW] == APER_TAG)
            tgt = TGT_APER;
        else if (word == BASE_W)
            tgt = TGT_BASE;
        else if (word == DATA_W_OFS)
            tgt = TGT_DATA;
        else
            tgt = TGT_NONE;
    end

endmodule

// File: rtl/wbr_addr_form.sv
// Module: wbr_addr_form
// Holds the window base register and forms the SRAM word address for
// aperture and data-register accesses, with an implemented-size check.
// Assumes: NUM_BANKS equal banks of 2^BANK_BYTE_AW bytes from address 0.
module wbr_addr_form
    import wbr_pkg::*;
#(
    parameter int WIN_AW       = 11,
    parameter int BANK_BYTE_AW = 19,
    parameter int NUM_BANKS    = 2,
    parameter int SRAM_WAW     = $clog2(NUM_BANKS) + BANK_BYTE_AW - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  base_wr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  use_aper,
    input  logic [WIN_AW-1:2]     aper_off,
    output logic [DATA_W-1:0]     base_q,
    output logic [SRAM_WAW-1:0]   word_addr,
    output logic                  in_range
);

    localparam logic [DATA_W:0] LIMIT_BYTES = (DATA_W+1)'(NUM_BANKS) << BANK_BYTE_AW;

    logic [DATA_W-1:0] byte_addr;

    // Base register: plain load, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (base_wr)
            base_q <= wdata;
    end

    // Byte address: aperture replaces the low window bits of the base
    always_comb begin
        if (use_aper)
            byte_addr = {base_q[DATA_W-1:WIN_AW], aper_off, 2'b00};
        else
            byte_addr = {base_q[DATA_W-1:2], 2'b00};
    end

    // Range check against the full implemented size, all 32 bits compared
    assign in_range  = {1'b0, byte_addr} < LIMIT_BYTES;
    assign word_addr = byte_addr[SRAM_WAW+1:2];

endmodule

// File: rtl/wbr_rd_return.sv
// Module: wbr_rd_return
// Registers the source of each host read and presents its data one cycle
// later, next to the SRAM read data of the same cycle.
// Assumes: SRAM read data is valid the cycle after its enable.
module wbr_rd_return
    import wbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_take,
    input  wbr_rsrc_e          rd_src,
    input  logic [DATA_W-1:0]  base_q,
    input  logic [DATA_W-1:0]  sram_rdata,
    output logic               rvalid,
    output logic [DATA_W-1:0]  rdata
);

    wbr_rsrc_e         src_q;
    logic [DATA_W-1:0] snap_q;

    // Read stage: remember whether a read was taken and where it reads from
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            src_q  <= RSRC_ZERO;
            snap_q <= '0;
        end else begin
            rvalid <= rd_take;
            src_q  <= rd_take ? rd_src : RSRC_ZERO;
            snap_q <= base_q;
        end
    end

    // Output mux: base snapshot, SRAM word, or zero
    always_comb begin
        case (src_q)
            RSRC_BASE: rdata = snap_q;
            RSRC_SRAM: rdata = sram_rdata;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/wbr_window_bridge.sv
// Module: wbr_window_bridge (top)
// Register-slave bridge from a small host register space into a large
// synchronous SRAM, through a sliding 2^WIN_AW-byte aperture and a
// single-word data register, both relative to a window base register.
// Assumes: the host raises at most one of reg_wr / reg_rd per cycle (a
// write wins if both are high); all accesses are 32-bit words.
module wbr_window_bridge
    import wbr_pkg::*;
#(
    parameter int REG_AW       = 12,
    parameter int WIN_AW       = 11,
    parameter int APER_OFS     = 'h800,
    parameter int BASE_OFS     = 'h68,
    parameter int DATA_OFS     = 'h6C,
    parameter int BANK_BYTE_AW = 19,
    parameter int NUM_BANKS    = 2,
    parameter int SRAM_WAW     = $clog2(NUM_BANKS) + BANK_BYTE_AW - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    input  logic                reg_wr,
    input  logic                reg_rd,
    output logic [31:0]         reg_rdata,
    output logic                reg_rvalid,
    output logic                sram_en,
    output logic                sram_we,
    output logic [SRAM_WAW-1:0] sram_addr,
    output logic [31:0]         sram_wdata,
    input  logic [31:0]         sram_rdata
);

    wbr_tgt_e          tgt;
    logic [31:0]       base_q;
    logic              in_range;
    logic              mem_tgt;
    logic              rd_take;
    wbr_rsrc_e         rd_src;

    wbr_decode #(
        .REG_AW   (REG_AW),
        .WIN_AW   (WIN_AW),
        .APER_OFS (APER_OFS),
        .BASE_OFS (BASE_OFS),
        .DATA_OFS (DATA_OFS)
    ) u_decode (
        .addr (reg_addr),
        .tgt  (tgt)
    );

    wbr_addr_form #(
        .WIN_AW       (WIN_AW),
        .BANK_BYTE_AW (BANK_BYTE_AW),
        .NUM_BANKS    (NUM_BANKS),
        .SRAM_WAW     (SRAM_WAW)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_wr   (reg_wr && tgt == TGT_BASE),
        .wdata     (reg_wdata),
        .use_aper  (tgt == TGT_APER),
        .aper_off  (reg_addr[WIN_AW-1:2]),
        .base_q    (base_q),
        .word_addr (sram_addr),
        .in_range  (in_range)
    );

    // SRAM port: memory targets within the implemented size only
    assign mem_tgt    = (tgt == TGT_DATA) || (tgt == TGT_APER);
    assign sram_en    = mem_tgt && in_range && (reg_wr || reg_rd);
    assign sram_we    = mem_tgt && in_range && reg_wr;
    assign sram_wdata = reg_wdata;

    // Read source selection for the return stage
    assign rd_take = reg_rd && !reg_wr;
    always_comb begin
        if (tgt == TGT_BASE)
            rd_src = RSRC_BASE;
        else if (mem_tgt && in_range)
            rd_src = RSRC_SRAM;
        else
            rd_src = RSRC_ZERO;
    end

    wbr_rd_return u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_take    (rd_take),
        .rd_src     (rd_src),
        .base_q     (base_q),
        .sram_rdata (sram_rdata),
        .rvalid     (reg_rvalid),
        .rdata      (reg_rdata)
    );

endmodule

// File: rtl/wbr_window_bridge_chk.sv
// Module: wbr_window_bridge_chk
// Port-level properties of the bridge, bound to every instance of the top.
module wbr_window_bridge_chk #(
    parameter int REG_AW       = 12,
    parameter int WIN_AW       = 11,
    parameter int APER_OFS     = 'h800,
    parameter int BASE_OFS     = 'h68,
    parameter int DATA_OFS     = 'h6C,
    parameter int BANK_BYTE_AW = 19,
    parameter int NUM_BANKS    = 2,
    parameter int SRAM_WAW     = 18
) (
    input logic                clk,
    input logic                rst_n,
    input logic [REG_AW-1:0]   reg_addr,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic                reg_rvalid,
    input logic                sram_en,
    input logic                sram_we,
    input logic [SRAM_WAW-1:0] sram_addr
);

    localparam logic [SRAM_WAW:0] LIMIT_WORDS = (SRAM_WAW+1)'(NUM_BANKS) << (BANK_BYTE_AW - 2);
    localparam int APER_END = APER_OFS + (1 << WIN_AW);

    logic is_aper, is_base, is_unmapped;
    assign is_aper     = (32'(reg_addr) >= 32'(APER_OFS)) && (32'(reg_addr) < 32'(APER_END));
    assign is_base     = (reg_addr[REG_AW-1:2] == (REG_AW-2)'(BASE_OFS >> 2));
    assign is_unmapped = !is_aper && !is_base &&
                         (reg_addr[REG_AW-1:2] != (REG_AW-2)'(DATA_OFS >> 2));

    assert_aper_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && is_aper && sram_en) |-> (sram_we && sram_addr[WIN_AW-3:0] == reg_addr[WIN_AW-1:2]));

    assert_rvalid_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr) |=> reg_rvalid);

    assert_no_spurious_rvalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && !reg_wr) |=> !reg_rvalid);

    assert_sram_in_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_en |-> ({1'b0, sram_addr} < LIMIT_WORDS));

    assert_unmapped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_unmapped |-> !sram_en);

    assert_base_no_sram_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_base |-> !sram_en);

    assert_we_with_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> sram_en);

endmodule

bind wbr_window_bridge wbr_window_bridge_chk #(
    .REG_AW       (REG_AW),
    .WIN_AW       (WIN_AW),
    .APER_OFS     (APER_OFS),
    .BASE_OFS     (BASE_OFS),
    .DATA_OFS     (DATA_OFS),
    .BANK_BYTE_AW (BANK_BYTE_AW),
    .NUM_BANKS    (NUM_BANKS),
    .SRAM_WAW     (SRAM_WAW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rvalid (reg_rvalid),
    .sram_en    (sram_en),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr)
);

// File: tb/wbr_window_bridge_tb_top.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares.
module wbr_window_bridge_tb_top;

    localparam int REG_AW       = 12;
    localparam int BANK_BYTE_AW = 12;
    localparam int NUM_BANKS    = 3;
    localparam int SRAM_WAW     = $clog2(NUM_BANKS) + BANK_BYTE_AW - 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [REG_AW-1:0]   reg_addr = '0;
    logic [31:0]         reg_wdata = '0;
    logic                reg_wr = 1'b0;
    logic                reg_rd = 1'b0;
    logic [31:0]         reg_rdata;
    logic                reg_rvalid;
    logic                sram_en, sram_we;
    logic [SRAM_WAW-1:0] sram_addr;
    logic [31:0]         sram_wdata;
    logic [31:0]         sram_rdata = '0;

    int checks = 0;
    int errors = 0;
    int sram_ops = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] mem [2**SRAM_WAW];

    always #10 clk = ~clk;

    wbr_window_bridge #(
        .REG_AW       (REG_AW),
        .BANK_BYTE_AW (BANK_BYTE_AW),
        .NUM_BANKS    (NUM_BANKS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .sram_en    (sram_en),
        .sram_we    (sram_we),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata)
    );

    // SRAM model with one cycle of read latency
    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) mem[sram_addr] <= sram_wdata;
            else         sram_rdata <= mem[sram_addr];
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read data and counts SRAM operations
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_en) sram_ops++;
            if (reg_rvalid) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected rvalid", 32'd1, 32'd0);
                end else begin
                    check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        int ops0;
        repeat (3) @(negedge clk);
        check("R5 reset rvalid", 32'(reg_rvalid), 32'd0);
        check("R9 reset sram_en", 32'(sram_en), 32'd0);
        rst_n = 1'b1;

        // R1 base register reset value and readback
        rd(12'h068, 32'h0, "R1 base reset");
        wr(12'h068, 32'hDEADBEEF);
        rd(12'h068, 32'hDEADBEEF, "R1 base readback");

        // R9 base accesses leave SRAM idle
        ops0 = sram_ops;
        wr(12'h068, 32'h0000_0800);
        rd(12'h068, 32'h0000_0800, "R1 base readback 2");
        repeat (2) @(negedge clk);
        check("R9 base no sram op", 32'(sram_ops - ops0), 32'd0);

        // R2 aperture address formation at both ends of the window
        wr(12'h800, 32'hA000_0000);
        wr(12'hFFC, 32'hA111_1111);
        wr(12'h068, 32'h0000_0800);
        rd(12'h06C, 32'hA000_0000, "R2 aperture low word");
        wr(12'h068, 32'h0000_0FFC);
        rd(12'h06C, 32'hA111_1111, "R2 aperture top word");

        // R3 base low bits ignored by the aperture
        wr(12'h068, 32'h0000_0ABC);
        wr(12'h804, 32'hB000_0B0B);
        rd(12'h804, 32'hB000_0B0B, "R3 aperture with low base bits");
        wr(12'h068, 32'h0000_0804);
        rd(12'h06C, 32'hB000_0B0B, "R3 same word via data reg");

        // R4 data register at base, low two bits ignored
        wr(12'h068, 32'h0000_1A07);
        wr(12'h06D, 32'hC0C0_C0C0);
        wr(12'h068, 32'h0000_1800);
        rd(12'hA04, 32'hC0C0_C0C0, "R4 data reg word via aperture");
        rd(12'hA07, 32'hC0C0_C0C0, "R4 reg addr low bits ignored");

        // R8 no carry across the window; next window needs a new base
        wr(12'h068, 32'h0000_1000);
        wr(12'h800, 32'hD000_000D);
        wr(12'h068, 32'h0000_0800);
        rd(12'hFFC, 32'hA111_1111, "R8 previous window top intact");
        wr(12'h068, 32'h0000_1000);
        rd(12'h06C, 32'hD000_000D, "R8 next window after rebase");

        // R6 last in-range word, then beyond the 12 KB limit
        wr(12'h068, 32'h0000_2800);
        wr(12'hFFC, 32'hE000_000E);
        wr(12'h068, 32'h0000_2FFC);
        rd(12'h06C, 32'hE000_000E, "R6 last in-range word");
        ops0 = sram_ops;
        wr(12'h068, 32'h0000_3000);
        wr(12'h800, 32'h1111_1111);
        wr(12'h06C, 32'h2222_2222);
        rd(12'h800, 32'h0, "R6 out of range aperture read");
        rd(12'h06C, 32'h0, "R6 out of range data read");
        wr(12'h068, 32'h8000_0804);
        wr(12'h06C, 32'h3333_3333);
        wr(12'h804, 32'h4444_4444);
        rd(12'h06C, 32'h0, "R6 high base read");
        repeat (2) @(negedge clk);
        check("R6 no sram op beyond limit", 32'(sram_ops - ops0), 32'd0);
        wr(12'h068, 32'h0000_0804);
        rd(12'h06C, 32'hB000_0B0B, "R6 no alias write");

        // R7 unmapped offsets
        ops0 = sram_ops;
        wr(12'h070, 32'h5555_5555);
        wr(12'h400, 32'h6666_6666);
        rd(12'h070, 32'h0, "R7 unmapped read 0x070");
        rd(12'h400, 32'h0, "R7 unmapped read 0x400");
        repeat (2) @(negedge clk);
        check("R7 no sram op", 32'(sram_ops - ops0), 32'd0);
        rd(12'h068, 32'h0000_0804, "R7 base unchanged");

        // R5 back-to-back reads return in order
        wr(12'h068, 32'h0000_0800);
        @(negedge clk);
        exp_q.push_back(32'hA000_0000); tag_q.push_back("R5 burst first");
        exp_q.push_back(32'hA111_1111); tag_q.push_back("R5 burst second");
        exp_q.push_back(32'h0000_0800); tag_q.push_back("R5 burst third");
        reg_addr = 12'h800; reg_rd = 1'b1;
        @(negedge clk);
        reg_addr = 12'hFFC;
        @(negedge clk);
        reg_addr = 12'h068;
        @(negedge clk);
        reg_rd = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 all reads returned", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule